// File: doc/BRIEF.md
# Token-Driven Two-Way Stream Select

This block is a dataflow operator that merges two 8-bit data streams into one output stream, steered by a stream of one-bit choices. Each input stream and the output stream use a valid/ready handshake. A transfer happens on a rising clock edge where both valid and ready are high.

The operator is a three-state machine. In its idle state it takes one choice token. The token sends it to the state for the chosen data stream. In that state it takes exactly one token from that stream and writes it into a single-entry output register. It then goes back to idle. The data stream that was not chosen sees no ready and keeps its token queued for a later choice. A state fires only when every input it needs has a token. A firing that writes the output also needs the output register to be free: either empty, or being drained in the same cycle. Reset is asynchronous and active low. The reset input is expected to be released synchronously to `clk`.

Top module: `tok_select`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it is released, `out_valid` is 0, `ctl_ready` is 1, and `tru_ready` and `fls_ready` are 0.
- R2: In the idle state `ctl_ready` is 1, while `tru_ready` and `fls_ready` are both 0. At most one of the three ready outputs is high in any cycle.
- R3: A choice token with `ctl_bit` = 1 moves the operator to the true-branch state. In that state only `tru_ready` may be high, and `ctl_ready` is 0.
- R4: A choice token with `ctl_bit` = 0 moves the operator to the false-branch state. In that state only `fls_ready` may be high, and `ctl_ready` is 0.
- R5: When a branch token is accepted, the next cycle has `out_valid` = 1 and `out_data` equal to that token, and the operator is back in the idle state. Outputs leave in the order of the choice tokens.
- R6: The stream that was not chosen is never acknowledged. Each data stream gives exactly one token for each choice token that selects it.
- R7: In a branch state where `out_valid` = 1 and `out_ready` = 0, the branch ready is 0. No token is consumed and the state holds.
- R8: While `out_valid` = 1 and `out_ready` = 0, the next cycle keeps `out_valid` = 1 and `out_data` unchanged.
- R9: When the output register is drained in the same cycle a branch token arrives, the branch ready is 1 in that cycle. The new token appears in the next cycle with no empty cycle in between.
- R10: In a branch state with no token on the chosen stream, the operator waits. It consumes nothing and does not change the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_valid | input | 1 | Choice stream has a token |
| ctl_bit | input | 1 | Choice token: 1 selects the true stream, 0 selects the false stream |
| ctl_ready | output | 1 | Choice token accepted on this edge |
| tru_valid | input | 1 | True data stream has a token |
| tru_data | input | 8 | True data token |
| tru_ready | output | 1 | True token accepted on this edge |
| fls_valid | input | 1 | False data stream has a token |
| fls_data | input | 8 | False data token |
| fls_ready | output | 1 | False token accepted on this edge |
| out_valid | output | 1 | Output register holds a token |
| out_data | output | 8 | Output token |
| out_ready | input | 1 | Consumer accepts the output token |

## Verification
Two actions can fall on the same edge: the consumer draining the output register, and a branch firing that refills it. A directed step holds the output stalled while a branch token waits, and checks that the branch ready stays low. It then raises `out_ready` and checks that the branch ready rises in that same cycle and that the new value follows on the next cycle with no gap. A long streaming run then varies the valid and ready densities across four patterns so that this overlap happens often. Each accepted output is matched against the token predicted from the choice sequence and each stream's own value formula.

// File: rtl/sel_pkg.sv
package sel_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_TRUE  = 2'd1,
    S_FALSE = 2'd2
  } sel_state_e;
endpackage

// File: rtl/sel_fire_ctrl.sv
module sel_fire_ctrl
  import sel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_valid,
  input  logic ctl_bit,
  input  logic tru_valid,
  input  logic fls_valid,
  input  logic slot_free,
  output logic ctl_ready,
  output logic tru_ready,
  output logic fls_ready,
  output logic load,
  output logic pick_true
);
  sel_state_e state_q;
  sel_state_e state_d;

  // next-state and firing decode
  always_comb begin
    state_d   = state_q;
    ctl_ready = 1'b0;
    tru_ready = 1'b0;
    fls_ready = 1'b0;
    load      = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        ctl_ready = 1'b1;
        if (ctl_valid) begin
          state_d = ctl_bit ? S_TRUE : S_FALSE;
        end
      end
      S_TRUE: begin
        tru_ready = slot_free;
        if (tru_valid && slot_free) begin
          load    = 1'b1;
          state_d = S_IDLE;
        end
      end
      S_FALSE: begin
        fls_ready = slot_free;
        if (fls_valid && slot_free) begin
          load    = 1'b1;
          state_d = S_IDLE;
        end
      end
      default: begin
        state_d = S_IDLE;
      end
    endcase
  end

  assign pick_true = (state_q == S_TRUE);

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
    end else begin
      state_q <= state_d;
    end
  end
endmodule

// File: rtl/sel_data_mux.sv
module sel_data_mux #(
  parameter int DATA_W = 8
) (
  input  logic              pick_true,
  input  logic [DATA_W-1:0] tru_data,
  input  logic [DATA_W-1:0] fls_data,
  output logic [DATA_W-1:0] mux_data
);
  always_comb begin
    mux_data = pick_true ? tru_data : fls_data;
  end
endmodule

// File: rtl/sel_out_slot.sv
module sel_out_slot #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              slot_free
);
  logic              valid_d;
  logic [DATA_W-1:0] data_d;

  assign slot_free = !out_valid || out_ready;

  always_comb begin
    valid_d = out_valid;
    data_d  = out_data;
    if (load) begin
      valid_d = 1'b1;
      data_d  = load_data;
    end else if (out_ready) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= valid_d;
    end
  end

  // data has no reset; only written under its clock enable
  always_ff @(posedge clk) begin
    if (load) begin
      out_data <= data_d;
    end
  end
endmodule

// File: rtl/tok_select.sv
module tok_select #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_valid,
  input  logic              ctl_bit,
  output logic              ctl_ready,
  input  logic              tru_valid,
  input  logic [DATA_W-1:0] tru_data,
  output logic              tru_ready,
  input  logic              fls_valid,
  input  logic [DATA_W-1:0] fls_data,
  output logic              fls_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready
);
  logic              slot_free;
  logic              load;
  logic              pick_true;
  logic [DATA_W-1:0] mux_data;

  sel_fire_ctrl u_fire (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_valid (ctl_valid),
    .ctl_bit   (ctl_bit),
    .tru_valid (tru_valid),
    .fls_valid (fls_valid),
    .slot_free (slot_free),
    .ctl_ready (ctl_ready),
    .tru_ready (tru_ready),
    .fls_ready (fls_ready),
    .load      (load),
    .pick_true (pick_true)
  );

  sel_data_mux #(.DATA_W(DATA_W)) u_mux (
    .pick_true (pick_true),
    .tru_data  (tru_data),
    .fls_data  (fls_data),
    .mux_data  (mux_data)
  );

  sel_out_slot #(.DATA_W(DATA_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_data (mux_data),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .slot_free (slot_free)
  );
endmodule

// File: rtl/sel_checks.sv
module sel_checks #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_valid,
  input logic              ctl_bit,
  input logic              ctl_ready,
  input logic              tru_valid,
  input logic [DATA_W-1:0] tru_data,
  input logic              tru_ready,
  input logic              fls_valid,
  input logic [DATA_W-1:0] fls_data,
  input logic              fls_ready,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_ready
);
  // R2: at most one stream acknowledged per cycle
  p_one_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl_ready, tru_ready, fls_ready}));

  // R3: a true choice leads into the true branch
  p_true_branch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && ctl_ready && ctl_bit) |=> (!ctl_ready && !fls_ready));

  // R4: a false choice leads into the false branch
  p_false_branch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && ctl_ready && !ctl_bit) |=> (!ctl_ready && !tru_ready));

  // R5: accepted true token appears at the output, then back to idle
  p_tru_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tru_valid && tru_ready) |=> (out_valid && out_data == $past(tru_data) && ctl_ready));

  // R5: accepted false token appears at the output, then back to idle
  p_fls_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fls_valid && fls_ready) |=> (out_valid && out_data == $past(fls_data) && ctl_ready));

  // R7: a blocked output stops every branch acknowledge
  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> (!tru_ready && !fls_ready));

  // R8: a waiting output token is held
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind tok_select sel_checks #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctl_valid (ctl_valid),
  .ctl_bit   (ctl_bit),
  .ctl_ready (ctl_ready),
  .tru_valid (tru_valid),
  .tru_data  (tru_data),
  .tru_ready (tru_ready),
  .fls_valid (fls_valid),
  .fls_data  (fls_data),
  .fls_ready (fls_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_ready (out_ready)
);

// File: tb/tok_select_tb.sv
module tok_select_tb;
  localparam int NTOK  = 1200;
  localparam int PHASE = 300;

  logic       clk;
  logic       rst_n;
  logic       ctl_valid, ctl_bit, ctl_ready;
  logic       tru_valid, tru_ready;
  logic [7:0] tru_data;
  logic       fls_valid, fls_ready;
  logic [7:0] fls_data;
  logic       out_valid, out_ready;
  logic [7:0] out_data;

  int tests  = 0;
  int failed = 0;
  bit done   = 0;

  int sel  [NTOK];
  int expv [NTOK];

  tok_select u_dut (
    .clk(clk), .rst_n(rst_n),
    .ctl_valid(ctl_valid), .ctl_bit(ctl_bit), .ctl_ready(ctl_ready),
    .tru_valid(tru_valid), .tru_data(tru_data), .tru_ready(tru_ready),
    .fls_valid(fls_valid), .fls_data(fls_data), .fls_ready(fls_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit gate(input int m, input int c, input int k);
    case (m)
      0: gate = 1'b1;
      1: gate = ((c + k) % 3) != 0;
      2: gate = ((c * 5 + k * 3) % 7) < 3;
      default: gate = 1'b1;
    endcase
  endfunction

  function automatic bit rgate(input int m, input int c);
    case (m)
      0: rgate = 1'b1;
      1: rgate = (c % 2) == 0;
      2: rgate = (c % 5) != 0;
      default: rgate = (c % 4) == 0;
    endcase
  endfunction

  function automatic bit cbit(input int i);
    cbit = 1'(((i * 13) >> 3) ^ i);
  endfunction

  function automatic logic [7:0] tval(input int i);
    tval = 8'((i * 37 + 5) & 255);
  endfunction

  function automatic logic [7:0] fval(input int i);
    fval = 8'((i * 91 + 200) & 255);
  endfunction

  initial begin
    #(20 * 150000);
    if (!done) begin
      failed++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    int ci, ti, fi, si, oi, ne, cyc, mode, trues;
    bit fc, ft, ff;
    rst_n = 1'b0;
    ctl_valid = 0; ctl_bit = 0; tru_valid = 0; tru_data = 0;
    fls_valid = 0; fls_data = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid && ctl_ready && !tru_ready && !fls_ready, "R1 in reset", out_valid, 0);
    rst_n = 1'b1;
    #1;
    chk(!out_valid && ctl_ready && !tru_ready && !fls_ready, "R1 after release", out_valid, 0);

    // R2/R3: true choice with output register empty
    ctl_valid = 1; ctl_bit = 1;
    #1 chk(ctl_ready && !tru_ready && !fls_ready, "R2 idle readies", ctl_ready, 1);
    @(negedge clk);
    ctl_valid = 0; tru_valid = 1; tru_data = 8'hA5;
    #1 chk(tru_ready && !fls_ready && !ctl_ready, "R3 true branch readies", tru_ready, 1);
    @(negedge clk);
    tru_valid = 0;
    #1 chk(out_valid && out_data == 8'hA5, "R5 first token", out_data, 8'hA5);
    ctl_valid = 1; ctl_bit = 1;
    @(negedge clk);
    ctl_valid = 0; tru_valid = 1; tru_data = 8'h3C;
    #1 chk(!tru_ready, "R7 stall blocks ready", tru_ready, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1 chk(out_valid && out_data == 8'hA5 && !tru_ready, "R8 held output", out_data, 8'hA5);
    end
    out_ready = 1;
    #1 chk(tru_ready, "R9 same-cycle drain and fire", tru_ready, 1);
    @(negedge clk);
    tru_valid = 0;
    #1 chk(out_valid && out_data == 8'h3C, "R9 no bubble", out_data, 8'h3C);
    ctl_valid = 1; ctl_bit = 0;
    @(negedge clk);
    ctl_valid = 0; tru_valid = 1; tru_data = 8'h77;
    #1 chk(!out_valid, "R5 drained", out_valid, 0);
    chk(fls_ready && !tru_ready && !ctl_ready, "R4 false branch readies", fls_ready, 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1 chk(!out_valid && !tru_ready && fls_ready, "R10 R6 wait without token", out_valid, 0);
    end
    fls_valid = 1; fls_data = 8'h5A; tru_valid = 0;
    @(negedge clk);
    fls_valid = 0;
    #1 chk(out_valid && out_data == 8'h5A, "R5 false token", out_data, 8'h5A);
    @(negedge clk);

    // streaming sweep over four density patterns
    ci = 0; ti = 0; fi = 0; si = 0; oi = 0; ne = 0; cyc = 0;
    fc = 0; ft = 0; ff = 0;
    while (oi < NTOK) begin
      @(negedge clk);
      cyc++;
      mode = oi / PHASE;
      if (fc) ctl_valid = 0;
      if (ft) tru_valid = 0;
      if (ff) fls_valid = 0;
      fc = 0; ft = 0; ff = 0;
      if (!ctl_valid && ci < NTOK) begin
        ctl_valid = gate(mode, cyc, 0); ctl_bit = cbit(ci);
      end
      if (!tru_valid) begin
        tru_valid = gate(mode, cyc, 1); tru_data = tval(ti);
      end
      if (!fls_valid) begin
        fls_valid = gate(mode, cyc, 2); fls_data = fval(fi);
      end
      out_ready = rgate(mode, cyc);
      #1;
      if (ctl_valid && ctl_ready) begin
        sel[ci] = int'(ctl_bit); ci++; fc = 1;
      end
      if (tru_valid && tru_ready) begin
        chk(si < ci && sel[si] == 1, "R6 true stream read only when chosen", si, ci);
        if (ne < NTOK) expv[ne] = int'(tru_data);
        ne++; si++; ti++; ft = 1;
      end
      if (fls_valid && fls_ready) begin
        chk(si < ci && sel[si] == 0, "R6 false stream read only when chosen", si, ci);
        if (ne < NTOK) expv[ne] = int'(fls_data);
        ne++; si++; fi++; ff = 1;
      end
      if (out_valid && out_ready) begin
        chk(oi < ne && int'(out_data) == expv[oi], "R5 streamed output order", int'(out_data), (oi < ne) ? expv[oi] : -1);
        oi++;
      end
    end
    trues = 0;
    for (int k = 0; k < NTOK; k++) trues += sel[k];
    chk(ti == trues, "R6 true stream token count", ti, trues);
    chk(fi == NTOK - trues, "R6 false stream token count", fi, NTOK - trues);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule